// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block sits between a 16-bit register bus and an analog-to-digital converter. It runs a scan over a range of channels that software picks. Each conversion is started by one of three sources: a write to the data address, a tick from a pacer timer outside the block, or an external trigger pulse.

The sequencer moves circularly from the first channel of the range to the last. It tells the converter which channel to sample and which gain and input mode that channel uses. It tags each 12-bit result with the channel number and stores the tagged word in a sample FIFO. Software drains the FIFO by reading the data address. An interrupt can be raised on every stored sample, or only once the FIFO is at least half full.

The converter is outside the block. In the same cycle as `conv_start`, it returns a result on `conv_result`.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, the status word at address 6 reads 0x0141. This is the control value 0x41 in bits [6:0] plus the empty flag in bit 8. `irq` is low.
- R2: A write to address 0 starts exactly one conversion when control bit 0 is set. With control bit 0 clear, the same write starts none.
- R3: When control bit 1 is set, each cycle with `pacer_tick` high starts one conversion. When control bit 3 is also set, a tick counts only while `ext_gate` is high.
- R4: When control bit 2 is set, each cycle with `ext_trig` high starts one conversion. Pacer ticks are ignored unless control bit 1 is set.
- R5: A write to address 4 sets the first scan channel from bits [3:0] and the last scan channel from bits [11:8]. It also restarts the scan at the first channel. After each conversion the scan moves to the next channel, and from the last channel it returns to the first.
- R6: Each stored word carries the converted channel in bits [15:12] and the conversion result in bits [11:0].
- R7: Samples come out in the order they were stored. Each read of address 0 removes one sample. A read of address 0 while the FIFO is empty returns the last sample removed and changes nothing.
- R8: A write to address 2 stores a range word for the channel named by the first-channel field of the latest address-4 write. Address 2 reads that word back. During a conversion, `conv_gain` carries bits [4:0] of the converted channel's range word and `conv_diff` carries bit 5.
- R9: When control bit 4 is set and bit 5 is clear, every stored sample sets the pending interrupt. The pending interrupt drives `irq` and status bit 11.
- R10: When control bits 4 and 5 are both set, the pending interrupt is set only by a store that leaves at least FIFO_DEPTH/2 entries. Status bit 9 shows that the fill level is at least FIFO_DEPTH/2.
- R11: The FIFO holds FIFO_DEPTH samples, 4096 by default. A conversion that finds the FIFO full is dropped. Status bit 10 sets when the FIFO becomes full and stays set, even after reads, until the FIFO is cleared.
- R12: Any write to address 8 clears the pending interrupt, whatever the data. Any write to address 9 empties the FIFO and clears the full flag, whatever the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reads of address 0 remove a sample) |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| pacer_tick | input | 1 | Tick from the pacer timer |
| ext_gate | input | 1 | Gate for pacer ticks |
| ext_trig | input | 1 | External trigger pulse |
| conv_start | output | 1 | A conversion happens this cycle |
| conv_chan | output | 4 | Channel being converted |
| conv_gain | output | 5 | Gain code of that channel |
| conv_diff | output | 1 | Differential input for that channel |
| conv_result | input | 12 | Converter result, valid with conv_start |
| irq | output | 1 | Pending interrupt |

## Verification
The in-module assertions check properties that must hold on every cycle. They check that the fill level never exceeds the depth and that the full flag stays set until a clear. They also check that an empty read leaves the fill level alone, that the scan wraps from the last channel to the first, and that a clear-interrupt write with no store in the same cycle lowers `irq`.

Some behaviours can only be shown by the bench scenarios. These are the tagged word contents and their order, the selection among trigger sources with gating, the per-channel gain routing, and the exact sample on which a half-full interrupt fires.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int CHAN_BITS  = 4,
  parameter int DATA_BITS  = 12,
  parameter int FIFO_DEPTH = 4096
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [4:0]           bus_addr,
  input  logic [15:0]          bus_wdata,
  output logic [15:0]          bus_rdata,
  input  logic                 pacer_tick,
  input  logic                 ext_gate,
  input  logic                 ext_trig,
  output logic                 conv_start,
  output logic [CHAN_BITS-1:0] conv_chan,
  output logic [4:0]           conv_gain,
  output logic                 conv_diff,
  input  logic [DATA_BITS-1:0] conv_result,
  output logic                 irq
);
  localparam int NCH  = 1 << CHAN_BITS;
  localparam int WW   = CHAN_BITS + DATA_BITS;
  localparam int PW   = $clog2(FIFO_DEPTH);
  localparam int CW   = PW + 1;
  localparam logic [CW-1:0] DEPTH = CW'(FIFO_DEPTH);
  localparam logic [CW-1:0] HALF  = CW'(FIFO_DEPTH / 2);

  logic [6:0]           ctrl_q;
  logic [CHAN_BITS-1:0] first_q, last_q, cur_q;
  logic [5:0]           range_q [NCH];
  logic [WW-1:0]        mem [FIFO_DEPTH];
  logic [PW-1:0]        wp_q, rp_q;
  logic [CW-1:0]        cnt_q, cnt_nx;
  logic                 full_q, irq_q;
  logic [WW-1:0]        last_rd_q;

  wire wr_data  = bus_wr && bus_addr == 5'd0;
  wire wr_range = bus_wr && bus_addr == 5'd2;
  wire wr_mux   = bus_wr && bus_addr == 5'd4;
  wire wr_ctrl  = bus_wr && bus_addr == 5'd6;
  wire clr_int  = bus_wr && bus_addr == 5'd8;
  wire clr_fifo = bus_wr && bus_addr == 5'd9;

  wire conv = (wr_data && ctrl_q[0])
           || (pacer_tick && ctrl_q[1] && (!ctrl_q[3] || ext_gate))
           || (ext_trig && ctrl_q[2]);
  wire empty = cnt_q == '0;
  wire push  = conv && cnt_q != DEPTH && !clr_fifo;
  wire pop   = bus_rd && bus_addr == 5'd0 && !empty && !clr_fifo;

  always_comb begin
    cnt_nx = cnt_q;
    if (push && !pop) cnt_nx = cnt_q + 1'b1;
    else if (pop && !push) cnt_nx = cnt_q - 1'b1;
  end

  wire irq_set = push && ctrl_q[4] && (!ctrl_q[5] || cnt_nx >= HALF);

  assign conv_start = conv;
  assign conv_chan  = cur_q;
  assign conv_gain  = range_q[cur_q][4:0];
  assign conv_diff  = range_q[cur_q][5];
  assign irq        = irq_q;

  always_comb begin
    case (bus_addr)
      5'd0:    bus_rdata = 16'(empty ? last_rd_q : mem[rp_q]);
      5'd2:    bus_rdata = {10'd0, range_q[first_q]};
      5'd6:    bus_rdata = {4'd0, irq_q, full_q, cnt_q >= HALF, empty, 1'b0, ctrl_q};
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= 7'h41;
      first_q   <= '0;
      last_q    <= '0;
      cur_q     <= '0;
      wp_q      <= '0;
      rp_q      <= '0;
      cnt_q     <= '0;
      full_q    <= 1'b0;
      irq_q     <= 1'b0;
      last_rd_q <= '0;
      for (int i = 0; i < NCH; i++) range_q[i] <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q <= bus_wdata[6:0];
      if (wr_range) range_q[first_q] <= bus_wdata[5:0];
      if (wr_mux) begin
        first_q <= bus_wdata[CHAN_BITS-1:0];
        last_q  <= bus_wdata[8 +: CHAN_BITS];
        cur_q   <= bus_wdata[CHAN_BITS-1:0];
      end else if (conv) begin
        cur_q <= (cur_q == last_q) ? first_q : cur_q + 1'b1;
      end
      if (clr_fifo) begin
        wp_q   <= '0;
        rp_q   <= '0;
        cnt_q  <= '0;
        full_q <= 1'b0;
      end else begin
        if (push) begin
          mem[wp_q] <= {cur_q, conv_result};
          wp_q      <= wp_q + 1'b1;
        end
        if (pop) begin
          last_rd_q <= mem[rp_q];
          rp_q      <= rp_q + 1'b1;
        end
        cnt_q <= cnt_nx;
        if ((conv && cnt_q == DEPTH) || cnt_nx == DEPTH) full_q <= 1'b1;
      end
      irq_q <= irq_set || (irq_q && !clr_int);
    end
  end

  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DEPTH);
  a_r11_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && !clr_fifo |=> full_q);
  a_r7_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 5'd0 && empty && !conv |=> cnt_q == '0);
  a_r5_scan_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    conv && !wr_mux && cur_q == last_q |=> conv_chan == $past(first_q));
  a_r12_clear_irq: assert property (@(posedge clk) disable iff (!rst_n)
    clr_int && !conv |=> !irq);
endmodule

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [4:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic pacer_tick = 0, ext_gate = 0, ext_trig = 0;
  logic conv_start, conv_diff, irq;
  logic [3:0] conv_chan;
  logic [4:0] conv_gain;
  logic [11:0] conv_result;

  int checks = 0, errors = 0;
  int stub_k = 0, exp_k = 0;
  logic [15:0] expq[$];
  logic [15:0] v;

  adc_scan_seq dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] res(int k);
    return 12'(k * 7 + 3);
  endfunction
  assign conv_result = res(stub_k);
  always @(posedge clk) if (rst_n && conv_start) stub_k <= stub_k + 1;

  task automatic check(string req, logic [15:0] act, logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic expect_conv(logic [3:0] ch);
    expq.push_back({ch, res(exp_k)});
    exp_k++;
  endtask

  task automatic peek(logic [4:0] a, output logic [15:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic rd_pop(output logic [15:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = 0; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic drain(string req);
    while (expq.size() > 0) begin
      logic [15:0] e;
      e = expq.pop_front();
      rd_pop(v);
      check(req, v, e);
    end
    peek(6, v);
    check(req, {15'd0, v[8]}, 16'd1);
  endtask

  task automatic pace(int n);
    @(negedge clk); pacer_tick = 1;
    repeat (n) @(negedge clk);
    pacer_tick = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    peek(6, v); check("R1 status", v, 16'h0141);
    check("R1 irq", {15'd0, irq}, 16'd0);

    // R8 per-channel range programming
    wr(4, 16'h0303); wr(2, 16'h0025);
    wr(4, 16'h0404); wr(2, 16'h0002);
    wr(4, 16'h0503);
    peek(2, v); check("R8 range readback", v, 16'h0025);

    // R2/R5/R6/R8 software triggers scanning 3..5 with wrap
    for (int i = 0; i < 4; i++) begin
      logic [3:0] ch;
      ch = (i == 3) ? 4'd3 : 4'(3 + i);
      @(negedge clk); bus_wr = 1; bus_addr = 0; bus_wdata = 16'hFFFF;
      #1;
      check("R5 scan channel", {12'd0, conv_chan}, {12'd0, ch});
      if (ch == 3) check("R8 gain/diff ch3", {10'd0, conv_diff, conv_gain}, 16'h0025);
      if (ch == 4) check("R8 gain/diff ch4", {10'd0, conv_diff, conv_gain}, 16'h0002);
      expect_conv(ch);
      @(negedge clk); bus_wr = 0;
    end
    drain("R6 R7 tagged words in order");
    // R7 empty read returns last value
    rd_pop(v); check("R7 empty read", v, {4'd3, res(3)});
    peek(6, v); check("R7 still empty", {15'd0, v[8]}, 16'd1);

    // R2 software write ignored without bit0
    wr(6, 16'h0040); wr(0, 16'h0000);
    peek(6, v); check("R2 no conversion", v & 16'h0F00, 16'h0100);

    // R3 pacer, then gated pacer
    wr(6, 16'h0042);
    pace(2); expect_conv(4); expect_conv(5);
    wr(6, 16'h004A);
    ext_gate = 0; pace(1);
    ext_gate = 1; pace(1); expect_conv(3); ext_gate = 0;
    drain("R3 pacer and gate");

    // R4 external trigger; pacer ignored
    wr(6, 16'h0044);
    pace(3);
    peek(6, v); check("R4 pacer ignored", v & 16'h0F00, 16'h0100);
    @(negedge clk); ext_trig = 1; @(negedge clk); ext_trig = 0;
    expect_conv(4);
    drain("R4 ext trigger");

    // R9 every-sample interrupt, R12 clear-int
    wr(6, 16'h0054);
    @(negedge clk); ext_trig = 1; @(negedge clk); ext_trig = 0;
    expect_conv(5);
    check("R9 irq", {15'd0, irq}, 16'd1);
    peek(6, v); check("R9 status bit11", {15'd0, v[11]}, 16'd1);
    wr(8, 16'hFFFF);
    check("R12 irq cleared", {15'd0, irq}, 16'd0);
    drain("R9 sample");

    // R10 half-full interrupt, R11 full, R12 clear fifo
    wr(4, 16'h0F00);
    wr(6, 16'h0072);
    pace(2047); exp_k += 2047;
    peek(6, v); check("R10 below half", {14'd0, v[11], v[9]}, 16'd0);
    pace(1); exp_k += 1;
    peek(6, v); check("R10 at half", {14'd0, v[11], v[9]}, 16'd3);
    wr(8, 16'h0000);
    pace(2058); exp_k += 2058;
    peek(6, v); check("R11 full set", {15'd0, v[10]}, 16'd1);
    rd_pop(v); check("R11 oldest kept", v, {4'd0, res(exp_k - 4106)});
    peek(6, v); check("R11 full sticky", {14'd0, v[10], v[8]}, 16'd2);
    wr(6, 16'h0040); wr(8, 16'h0000);
    wr(9, 16'h1234);
    peek(6, v); check("R12 fifo cleared", v, 16'h0140);
    check("R12 stub count", 16'(stub_k), 16'(exp_k));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule